// File: doc/BRIEF.md
# Pixel Unpacker with Palette Lookup

This block sits between a video memory read stream and the colour output of a display pipeline. It takes 16-bit memory words through a ready/valid handshake and produces one 24-bit RGB value per pixel. Every clock cycle is one pixel slot. A 2-bit mode input selects how a word is read. In indexed mode each word carries two 8-bit colour indices, and each index selects an entry of a 256-entry palette of 24-bit colours. In the true-colour modes the palette is not used. The pixel bits become the red, green and blue channels directly, either from one word (15 and 16 bits per pixel) or from a pair of words (24/32 bits per pixel).

Software fills the palette through a synchronous write port. Palette reads take one clock. The direct path carries a matching register stage, so every pixel appears on the output exactly one cycle after the cycle in which it was produced, whatever the mode. The mode is sampled only when a new word group starts. A change in the middle of a group therefore never splits a word between two interpretations.

Top module: `palette_pixel_unpacker`

## Requirements
- R1: While reset is held, out_valid is 0 and in_ready is 1. The pixel pipeline holds no pending pixel or half word when reset is released.
- R2: Mode encoding 0 selects indexed colour. An accepted word gives two pixels, bits 7..0 first and bits 15..8 in the next cycle. Each pixel's out_rgb is the palette entry that its byte addresses.
- R3: In indexed mode in_ready is 0 in the cycle that outputs the upper pixel of a word, so a streaming source delivers one word every second cycle.
- R4: Mode encoding 2 treats bits 15..11, 10..5 and 4..0 as red, green and blue. Each channel is widened to 8 bits by appending its own most significant bits. out_rgb is {red, green, blue} with red in bits 23..16.
- R5: Mode encoding 1 treats bits 14..10, 9..5 and 4..0 as red, green and blue, widened as in R4. Bit 15 has no effect on the output.
- R6: Mode encoding 3 takes two words per pixel. The first word gives green in bits 15..8 and blue in bits 7..0. The second word gives red in bits 7..0, and its bits 15..8 have no effect. No pixel is output after the first word alone, even if idle cycles separate the two words.
- R7: A palette write is stored at the clock edge where pal_we is sampled high. A lookup at that same edge returns the earlier contents, and a lookup at any later edge returns the written colour.
- R8: A pixel produced in a cycle appears on out_valid and out_rgb in the next cycle, in every mode.
- R9: mode_sel is sampled only when a word group starts: the first word in modes 1 to 3, or a word with no upper pixel pending in mode 0. Changing it while an upper pixel or a second half word is outstanding does not change how that group is decoded.
- R10: In a cycle after one in which no pixel was produced, out_valid is 0 and out_rgb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 indexed, 1 5-5-5, 2 5-6-5, 3 two-word 8-8-8 |
| in_valid | input | 1 | Memory word offered |
| in_word | input | 16 | Memory word |
| in_ready | output | 1 | Block takes the word this cycle |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette write entry |
| pal_data | input | 24 | Palette write colour {R,G,B} |
| out_valid | output | 1 | Pixel present on out_rgb |
| out_rgb | output | 24 | Pixel colour {R,G,B} |

## Verification
The bench builds the block with its default sizes: 16-bit words, 8-bit indices and 8-bit channels. These sizes bring the first and last palette entries, the all-ones and all-zeros channel codes, and the ignored top bits of the 5-5-5 and second 8-8-8 words within reach of directed stimulus. The bench also places a palette write and a lookup of the same entry on one clock edge. It switches the mode in the middle of both kinds of two-cycle group.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int PXU_WORD_W = 16;
  localparam int PXU_CHAN_W = 8;
  localparam int PXU_IDX_W  = 8;
  localparam int PXU_RGB_W  = 3 * PXU_CHAN_W;

  typedef enum logic [1:0] {
    PXM_IDX8   = 2'd0,
    PXM_RGB555 = 2'd1,
    PXM_RGB565 = 2'd2,
    PXM_RGB888 = 2'd3
  } pxu_mode_e;

  // widen a 5-bit channel by repeating its top bits
  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [PXU_RGB_W-1:0] map565(input logic [PXU_WORD_W-1:0] w);
    return {widen5(w[15:11]), widen6(w[10:5]), widen5(w[4:0])};
  endfunction

  function automatic logic [PXU_RGB_W-1:0] map555(input logic [PXU_WORD_W-1:0] w);
    return {widen5(w[14:10]), widen5(w[9:5]), widen5(w[4:0])};
  endfunction
endpackage

// File: rtl/pxu_word_split.sv
module pxu_word_split
  import pxu_pkg::*;
#(
  parameter int WORD_W = PXU_WORD_W,
  parameter int IDX_W  = PXU_IDX_W,
  parameter int RGB_W  = PXU_RGB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              accept,
  output logic              pend_hi,
  output logic              grp_open,
  output pxu_mode_e         act_mode,
  output logic              pix_fire,
  output logic              pix_use_pal,
  output logic [IDX_W-1:0]  pix_index,
  output logic [RGB_W-1:0]  pix_direct
);
  localparam int HALF_W = WORD_W / 2;

  logic              pend_hi_q;
  logic              half_q;
  logic [IDX_W-1:0]  hi_byte_q;
  logic [WORD_W-1:0] lo_word_q;
  pxu_mode_e         mode_q;
  logic              boundary;

  assign boundary = !pend_hi_q && !half_q;
  assign act_mode = boundary ? pxu_mode_e'(mode_sel) : mode_q;
  assign in_ready = !pend_hi_q;
  assign accept   = in_valid && in_ready;
  assign pend_hi  = pend_hi_q;
  assign grp_open = !boundary;

  always_comb begin
    pix_fire    = 1'b0;
    pix_use_pal = 1'b0;
    pix_index   = '0;
    pix_direct  = '0;
    if (pend_hi_q) begin
      pix_fire    = 1'b1;
      pix_use_pal = 1'b1;
      pix_index   = hi_byte_q;
    end else if (accept) begin
      case (act_mode)
        PXM_IDX8: begin
          pix_fire    = 1'b1;
          pix_use_pal = 1'b1;
          pix_index   = in_word[IDX_W-1:0];
        end
        PXM_RGB555: begin
          pix_fire   = 1'b1;
          pix_direct = map555(in_word);
        end
        PXM_RGB565: begin
          pix_fire   = 1'b1;
          pix_direct = map565(in_word);
        end
        default: begin
          if (half_q) begin
            pix_fire   = 1'b1;
            pix_direct = {in_word[HALF_W-1:0], lo_word_q};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi_q <= 1'b0;
      half_q    <= 1'b0;
      hi_byte_q <= '0;
      lo_word_q <= '0;
      mode_q    <= PXM_IDX8;
    end else if (pend_hi_q) begin
      pend_hi_q <= 1'b0;
    end else if (accept) begin
      if (boundary) mode_q <= pxu_mode_e'(mode_sel);
      case (act_mode)
        PXM_IDX8: begin
          pend_hi_q <= 1'b1;
          hi_byte_q <= in_word[WORD_W-1:HALF_W];
        end
        PXM_RGB888: begin
          if (half_q) begin
            half_q <= 1'b0;
          end else begin
            half_q    <= 1'b1;
            lo_word_q <= in_word;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pxu_palette_ram.sv
module pxu_palette_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-before-write: a lookup on the write edge sees the old entry
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pxu_out_stage.sv
module pxu_out_stage #(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_fire,
  input  logic             pix_use_pal,
  input  logic [RGB_W-1:0] pix_direct,
  input  logic [RGB_W-1:0] pal_rd,
  output logic             out_valid,
  output logic [RGB_W-1:0] out_rgb
);
  logic             valid_q;
  logic             use_pal_q;
  logic [RGB_W-1:0] direct_q;

  // this register stage matches the one-cycle palette read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      use_pal_q <= 1'b0;
      direct_q  <= '0;
    end else begin
      valid_q   <= pix_fire;
      use_pal_q <= pix_use_pal;
      direct_q  <= pix_direct;
    end
  end

  assign out_valid = valid_q;
  assign out_rgb   = !valid_q ? '0 : (use_pal_q ? pal_rd : direct_q);
endmodule

// File: rtl/palette_pixel_unpacker.sv
module palette_pixel_unpacker
  import pxu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        in_ready,
  input  logic        pal_we,
  input  logic [7:0]  pal_addr,
  input  logic [23:0] pal_data,
  output logic        out_valid,
  output logic [23:0] out_rgb
);
  // named internal events for the checker
  logic                 w_accept;
  logic                 w_pend_hi;
  logic                 w_grp_open;
  pxu_mode_e            w_act_mode;
  logic                 w_pix_fire;
  logic                 w_use_pal;
  logic [PXU_IDX_W-1:0] w_index;
  logic [PXU_RGB_W-1:0] w_direct;
  logic [PXU_RGB_W-1:0] w_pal_rd;

  pxu_word_split #(
    .WORD_W(PXU_WORD_W), .IDX_W(PXU_IDX_W), .RGB_W(PXU_RGB_W)
  ) u_split (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .accept(w_accept), .pend_hi(w_pend_hi), .grp_open(w_grp_open),
    .act_mode(w_act_mode), .pix_fire(w_pix_fire), .pix_use_pal(w_use_pal),
    .pix_index(w_index), .pix_direct(w_direct)
  );

  pxu_palette_ram #(
    .ADDR_W(PXU_IDX_W), .DATA_W(PXU_RGB_W)
  ) u_pal (
    .clk(clk), .wr_en(pal_we), .wr_addr(pal_addr), .wr_data(pal_data),
    .rd_addr(w_index), .rd_data(w_pal_rd)
  );

  pxu_out_stage #(
    .RGB_W(PXU_RGB_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .pix_fire(w_pix_fire), .pix_use_pal(w_use_pal),
    .pix_direct(w_direct), .pal_rd(w_pal_rd),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
  import pxu_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      in_valid,
  input logic      in_ready,
  input logic      out_valid,
  input logic      accept,
  input logic      pend_hi,
  input logic      grp_open,
  input pxu_mode_e act_mode,
  input logic      pix_fire
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));

  assert_idx_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act_mode == PXM_IDX8) |=> (pix_fire && !in_ready));

  assert_wide_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act_mode == PXM_RGB888 && !grp_open) |-> !pix_fire);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fire |=> out_valid);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_open |-> $stable(act_mode));

  assert_idle_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_fire |=> !out_valid);

  assert_no_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !pend_hi) |-> !pix_fire);
endmodule

bind palette_pixel_unpacker pxu_checker u_pxu_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .accept(w_accept), .pend_hi(w_pend_hi),
  .grp_open(w_grp_open), .act_mode(w_act_mode), .pix_fire(w_pix_fire)
);

// File: tb/test_palette_pixel_unpacker.sv
`timescale 1ns/1ps
module test_palette_pixel_unpacker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        in_valid;
  logic [15:0] in_word;
  logic        in_ready;
  logic        pal_we;
  logic [7:0]  pal_addr;
  logic [23:0] pal_data;
  logic        out_valid;
  logic [23:0] out_rgb;

  int n_checks = 0;
  int n_errors = 0;
  logic [23:0] pm [256];

  always #2.5 clk = ~clk;

  palette_pixel_unpacker i_palette_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_word(in_word), .in_ready(in_ready), .pal_we(pal_we),
    .pal_addr(pal_addr), .pal_data(pal_data), .out_valid(out_valid),
    .out_rgb(out_rgb)
  );

  // {mode, word}: single-word true-colour cases
  localparam logic [17:0] VEC [10] = '{
    {2'd2, 16'hFFFF}, {2'd2, 16'h0000}, {2'd2, 16'hF800}, {2'd2, 16'h07E0},
    {2'd2, 16'h001F}, {2'd2, 16'h8410}, {2'd1, 16'h7FFF}, {2'd1, 16'h8000},
    {2'd1, 16'hFFFF}, {2'd1, 16'h2A55}
  };

  function automatic logic [7:0] grow(input int v, input int bits);
    int r;
    r = (v << (8 - bits)) | (v >> (2 * bits - 8));
    return r[7:0];
  endfunction

  function automatic logic [23:0] expect_word(input logic [1:0] m, input logic [15:0] w);
    int r, g, b;
    if (m == 2'd2) begin
      r = (w >> 11) & 31; g = (w >> 5) & 63; b = w & 31;
      return {grow(r, 5), grow(g, 6), grow(b, 5)};
    end
    r = (w >> 10) & 31; g = (w >> 5) & 31; b = w & 31;
    return {grow(r, 5), grow(g, 5), grow(b, 5)};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = a; pal_data = d;
    pm[a] = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic send_one(input logic [1:0] m, input logic [15:0] w);
    @(negedge clk);
    mode_sel = m; in_word = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'd0; in_valid = 1'b0; in_word = '0;
    pal_we = 1'b0; pal_addr = '0; pal_data = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {7'd0, out_valid, out_rgb}, 32'd0);

    // table walk: single-word true-colour modes, one-cycle latency
    for (int i = 0; i < 10; i++) begin
      send_one(VEC[i][17:16], VEC[i][15:0]);
      check("R4/R5/R8 valid", {31'd0, out_valid}, 32'd1);
      check(VEC[i][17:16] == 2'd2 ? "R4 565 colour" : "R5 555 colour",
            {8'd0, out_rgb}, {8'd0, expect_word(VEC[i][17:16], VEC[i][15:0])});
    end

    // palette fill
    pal_write(8'h00, 24'h102030);
    pal_write(8'hFF, 24'hA1B2C3);
    pal_write(8'h3C, 24'h0F0F0F);
    pal_write(8'h81, 24'h445566);

    // indexed: low byte then high byte
    @(negedge clk);
    mode_sel = 2'd0; in_word = 16'hFF00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 first pixel valid", {31'd0, out_valid}, 32'd1);
    check("R2 low byte colour", {8'd0, out_rgb}, {8'd0, pm[8'h00]});
    check("R3 ready low during upper pixel", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R2 second pixel valid", {31'd0, out_valid}, 32'd1);
    check("R2 high byte colour", {8'd0, out_rgb}, {8'd0, pm[8'hFF]});
    check("R3 ready back", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    check("R10 idle after pair", {7'd0, out_valid, out_rgb}, 32'd0);

    // streaming: in_valid held, one word every second cycle
    @(negedge clk);
    mode_sel = 2'd0; in_word = 16'h8100; in_valid = 1'b1;
    @(negedge clk);
    check("R3 stream p0", {8'd0, out_rgb}, {8'd0, pm[8'h00]});
    check("R3 stream ready low", {31'd0, in_ready}, 32'd0);
    in_word = 16'h00FF;
    @(negedge clk);
    check("R3 stream p1 from held word", {8'd0, out_rgb}, {8'd0, pm[8'h81]});
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 stream p2", {8'd0, out_rgb}, {8'd0, pm[8'hFF]});
    @(negedge clk);
    check("R3 stream p3", {8'd0, out_rgb}, {8'd0, pm[8'h00]});

    // R7: write and lookup on the same edge
    @(negedge clk);
    pal_we = 1'b1; pal_addr = 8'h3C; pal_data = 24'hC0FFEE;
    mode_sel = 2'd0; in_word = 16'h3C3C; in_valid = 1'b1;
    @(negedge clk);
    pal_we = 1'b0; in_valid = 1'b0;
    check("R7 same-edge lookup sees old entry", {8'd0, out_rgb}, {8'd0, pm[8'h3C]});
    pm[8'h3C] = 24'hC0FFEE;
    @(negedge clk);
    check("R7 later lookup sees new entry", {8'd0, out_rgb}, 32'h00C0FFEE);

    // R6: two-word true colour with idle gap
    @(negedge clk);
    mode_sel = 2'd3; in_word = 16'h1234; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 no pixel after first half", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R6 still no pixel in gap", {7'd0, out_valid, out_rgb}, 32'd0);
    in_word = 16'hEE56; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 pixel after second half", {7'd0, out_valid, out_rgb}, {7'd0, 1'b1, 24'h561234});

    // R9: mode change between the halves of a two-word pixel
    @(negedge clk);
    mode_sel = 2'd3; in_word = 16'hABCD; in_valid = 1'b1;
    @(negedge clk);
    mode_sel = 2'd2; in_word = 16'h0077;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second half still 888", {8'd0, out_rgb}, 32'h0077ABCD);

    // R9: mode change while an upper index is pending
    @(negedge clk);
    mode_sel = 2'd0; in_word = 16'hFF81; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; mode_sel = 2'd2;
    check("R9 low index", {8'd0, out_rgb}, {8'd0, pm[8'h81]});
    @(negedge clk);
    check("R9 upper index still palette", {8'd0, out_rgb}, {8'd0, pm[8'hFF]});
    in_word = 16'hF800; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 new mode at next word", {8'd0, out_rgb}, 32'h00FF0000);

    // R1: reset in mid-group drops the pending upper pixel
    @(negedge clk);
    mode_sel = 2'd0; in_word = 16'hFF00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset clears pending", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 no stale pixel after reset", {7'd0, out_valid, out_rgb}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule